// File: doc/BRIEF.md
# Fixed-Priority Packet Memory Arbiter

This block shares one synchronous packet memory among four clients: an internal refresh generator, a descriptor mover, the network-side stage and the host-side stage. Each external client raises a level request and gives an access type: either a single word or an aligned burst of eight 32-bit words. The arbiter chooses one client, holds its grant for exactly the number of cycles that access needs, and moves the chosen client's address and data to the memory. The chosen client holds its request until it sees its grant. It then drops the request and gives one write word in each grant cycle.

The priority is fixed. The arbiter keeps this safe through protocol rules that it also checks. Refresh occurs rarely and lasts two cycles. The descriptor mover only ever makes single-word accesses and must stay silent for two cycles after each grant. A burst is never cut short. A host request that has waited longer than a programmed limit moves ahead of the network stage for one grant. Refresh is timed by a programmable cycle counter inside the block. A refresh that falls due during a burst is served as soon as the burst completes.

Top module: `pkt_mem_arbiter`

## Requirements
- R1: After reset all four grant bits, `rvalid_o` and `spacing_err_o` are low.
- R2: At most one grant bit is high in any cycle. A grant stays high for exactly the length of its access: 1 cycle for a single word, 8 cycles for a burst and 2 cycles for refresh. Nothing shortens it.
- R3: When several clients compete at a decision point, the winner follows this order, highest first: refresh (grant bit 0), mover (request index 0, grant bit 1), network (request index 1, grant bit 2), host (request index 2, grant bit 3). An idle arbiter grants one cycle after it sees the request.
- R4: The next grant starts in the cycle directly after the last cycle of the previous grant, with no idle cycle between them.
- R5: A refresh falls due every `rfsh_period_i` cycles and always comes from the block's own timer. A refresh that is delayed does not shift the times at which later refreshes fall due.
- R6: A refresh that falls due during a burst waits until that burst ends. It is granted in the cycle right after the burst's last cycle.
- R7: For the mover, `burst_i[0]` has no effect. Every mover grant is a single word lasting one cycle.
- R8: A mover request in either of the two cycles that follow its last grant cycle is not granted. In the next cycle, `spacing_err_o` goes high. A request in the third cycle is legal and raises no error.
- R9: When the host has waited more than `age_limit_i` cycles, it wins over the network stage at the next decision point. The arbiter then does not promote the host again until the network stage has been granted.
- R10: A pending network request is granted within a bounded number of cycles. The bound is set by the burst, refresh and single-word lengths, and holds whenever the refresh period is longer than that bound.
- R11: A burst's base address is the request address with its low 3 bits cleared. Beat i writes or reads word base+i, and `wdata_i` is sampled once per grant cycle. A single-word access uses the exact address given. Read data appears on `rdata_o`, with `rvalid_o` high, in the cycle after each beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rfsh_period_i | input | 16 | Number of cycles between refresh due points |
| age_limit_i | input | 8 | Host wait threshold, in cycles, above which the host is promoted |
| req_i | input | 3 | Request per client: 0 mover, 1 network, 2 host |
| burst_i | input | 3 | Per client: 1 requests an 8-word burst, 0 requests a single word |
| wr_i | input | 3 | Per client: 1 for a write, 0 for a read |
| addr_i | input | 18 | Word address per client, 6 bits each, client 0 in the lowest bits |
| wdata_i | input | 96 | Write word per client, 32 bits each, client 0 in the lowest bits |
| gnt_o | output | 4 | One-hot grant: 0 refresh, 1 mover, 2 network, 3 host |
| rdata_o | output | 32 | Read word |
| rvalid_o | output | 1 | High when `rdata_o` holds a read beat |
| spacing_err_o | output | 1 | High when the mover broke its two-cycle quiet rule |

## Verification
The assertions check four properties on every cycle: grants stay one-hot, a grant is held while beats remain, a due refresh is taken at every free point, and the mover stays quiet in the two cycles after its grant ends. They also check that an eligible promoted host wins the next grant and that network waiting never exceeds its bound. Other behaviour can only be shown by the bench's scenarios, because it depends on the exact cycle numbers a request produces. Those scenarios cover the full winner order and promotion under simultaneous requests, the refresh period and where it lands after a burst, mover spacing on both sides of the limit, and burst alignment with data returned word for word.

// File: rtl/pmarb_pkg.sv
// Shared types and indices for the packet memory arbiter.
// Assumes three external clients plus the internal refresh client.
package pmarb_pkg;
    localparam int NUM_CLIENTS = 3;
    localparam int CL_MOVER = 0;
    localparam int CL_NET   = 1;
    localparam int CL_HOST  = 2;

    localparam int GB_RFSH  = 0;
    localparam int GB_MOVER = 1;
    localparam int GB_NET   = 2;
    localparam int GB_HOST  = 3;

    typedef enum logic [2:0] {
        OWN_NONE,
        OWN_RFSH,
        OWN_MOVER,
        OWN_NET,
        OWN_HOST
    } owner_e;
endpackage

// File: rtl/pmarb_refresh_timer.sv
// Free-running refresh timer. It raises a pending flag every period_i cycles
// and drops the flag once the arbiter starts serving it. Assumes period_i stays
// stable. The schedule is independent of when each refresh is served.
module pmarb_refresh_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] period_i,
    input  logic             served_i,
    output logic             pend_o
);
    logic [REF_W-1:0] cnt_q;
    logic             tick;

    // Due point: the counter has reached the last cycle of the period.
    assign tick = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period_i};

    // Count cycles and keep the pending flag until it is served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_o <= 1'b0;
        end else begin
            cnt_q  <= tick ? '0 : cnt_q + 1'b1;
            pend_o <= (pend_o && !served_i) || tick;
        end
    end
endmodule

// File: rtl/pmarb_select.sv
// Combinational fixed-priority selector. Refresh beats the mover, the mover
// beats the network stage and the network stage beats the host, except that
// a promoted host moves ahead of the network stage. Assumes elig_i already
// excludes the current owner and any mover held in its quiet window.
module pmarb_select
    import pmarb_pkg::*;
(
    input  logic                   rfsh_pend_i,
    input  logic [NUM_CLIENTS-1:0] elig_i,
    input  logic                   promote_i,
    output owner_e                 winner_o,
    output logic                   valid_o
);
    // Pick the highest-priority eligible client.
    always_comb begin
        winner_o = OWN_NONE;
        if (rfsh_pend_i)                        winner_o = OWN_RFSH;
        else if (elig_i[CL_MOVER])              winner_o = OWN_MOVER;
        else if (elig_i[CL_HOST] && promote_i)  winner_o = OWN_HOST;
        else if (elig_i[CL_NET])                winner_o = OWN_NET;
        else if (elig_i[CL_HOST])               winner_o = OWN_HOST;
    end

    assign valid_o = (winner_o != OWN_NONE);
endmodule

// File: rtl/pkt_mem_arbiter.sv
// Packet memory arbiter top. It grants one client at a time in fixed priority,
// holds each grant for the access's full cycle count, ages the host, checks
// mover spacing and models the memory as a synchronous word array.
// Assumes each client holds its request until it sees its grant, then drops it.
module pkt_mem_arbiter
    import pmarb_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 32,
    parameter int BURST_BEATS = 8,
    parameter int LW_CYCLES   = 1,
    parameter int REF_CYCLES  = 2,
    parameter int REF_W       = 16,
    parameter int AGE_W       = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [REF_W-1:0]          rfsh_period_i,
    input  logic [AGE_W-1:0]          age_limit_i,
    input  logic [NUM_CLIENTS-1:0]    req_i,
    input  logic [NUM_CLIENTS-1:0]    burst_i,
    input  logic [NUM_CLIENTS-1:0]    wr_i,
    input  logic [NUM_CLIENTS*AW-1:0] addr_i,
    input  logic [NUM_CLIENTS*DW-1:0] wdata_i,
    output logic [3:0]                gnt_o,
    output logic [DW-1:0]             rdata_o,
    output logic                      rvalid_o,
    output logic                      spacing_err_o
);
    localparam int DEPTH     = 1 << AW;
    localparam int MAXLEN    = (BURST_BEATS > REF_CYCLES) ? BURST_BEATS : REF_CYCLES;
    localparam int LEN_W     = $clog2(MAXLEN + 1);
    localparam int NET_BOUND = 2 * MAXLEN + 2 * REF_CYCLES + 2 * LW_CYCLES + 4;
    localparam int NW_W      = $clog2(NET_BOUND + 2) + 1;

    logic [AW-1:0] addr_a  [NUM_CLIENTS];
    logic [DW-1:0] wdata_a [NUM_CLIENTS];

    // Split the flat client buses into per-client arrays.
    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_unpack
        assign addr_a[c]  = addr_i[c*AW +: AW];
        assign wdata_a[c] = wdata_i[c*DW +: DW];
    end

    owner_e             owner_q;
    logic [LEN_W-1:0]   remain_q, len_q;
    logic [AW-1:0]      base_q;
    logic               wr_q, burst_q;
    logic [1:0]         guard_q;
    logic [AGE_W-1:0]   host_wait_q;
    logic               promo_used_q;
    logic               rfsh_pend;
    logic               free, start, win_valid, promote;
    owner_e             winner;
    logic [NUM_CLIENTS-1:0] elig;
    logic [1:0]         win_client, cur_client;
    logic [LEN_W-1:0]   win_len;
    logic               win_burst;
    logic [AW-1:0]      win_addr, cur_addr;
    logic [LEN_W-1:0]   beat;
    logic               data_phase;
    logic [DW-1:0]      mem [DEPTH];

    // Map an owner to its client index for the data buses.
    function automatic logic [1:0] client_of(owner_e o);
        case (o)
            OWN_MOVER: return 2'(CL_MOVER);
            OWN_NET:   return 2'(CL_NET);
            default:   return 2'(CL_HOST);
        endcase
    endfunction

    // A decision can be made when idle or in the final cycle of a grant.
    assign free = (remain_q <= LEN_W'(1));

    // Eligibility: the current owner is excluded, and so is a mover in its quiet window.
    always_comb begin
        elig[CL_MOVER] = req_i[CL_MOVER] && (guard_q == 2'd0) && (owner_q != OWN_MOVER);
        elig[CL_NET]   = req_i[CL_NET]   && (owner_q != OWN_NET);
        elig[CL_HOST]  = req_i[CL_HOST]  && (owner_q != OWN_HOST);
    end

    assign promote = (host_wait_q > age_limit_i) && !promo_used_q;

    pmarb_refresh_timer #(.REF_W(REF_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (rfsh_period_i),
        .served_i (start && (winner == OWN_RFSH)),
        .pend_o   (rfsh_pend)
    );

    pmarb_select i_select (
        .rfsh_pend_i (rfsh_pend),
        .elig_i      (elig),
        .promote_i   (promote),
        .winner_o    (winner),
        .valid_o     (win_valid)
    );

    assign start = free && win_valid;

    // Length, burst flag and aligned base address of the winning access.
    always_comb begin
        win_client = client_of(winner);
        win_burst  = (winner == OWN_NET || winner == OWN_HOST) && burst_i[win_client];
        win_addr   = win_burst ? (addr_a[win_client] & ~AW'(BURST_BEATS - 1))
                               : addr_a[win_client];
        case (winner)
            OWN_RFSH: win_len = LEN_W'(REF_CYCLES);
            default:  win_len = win_burst ? LEN_W'(BURST_BEATS) : LEN_W'(LW_CYCLES);
        endcase
    end

    // Grant state: start a new access or count down the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q  <= OWN_NONE;
            remain_q <= '0;
            len_q    <= '0;
            base_q   <= '0;
            wr_q     <= 1'b0;
            burst_q  <= 1'b0;
        end else if (start) begin
            owner_q  <= winner;
            remain_q <= win_len;
            len_q    <= win_len;
            base_q   <= win_addr;
            wr_q     <= wr_i[win_client] && (winner != OWN_RFSH);
            burst_q  <= win_burst;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == LEN_W'(1)) owner_q <= OWN_NONE;
        end
    end

    // Mover quiet window and the spacing-violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q       <= 2'd0;
            spacing_err_o <= 1'b0;
        end else begin
            if (owner_q == OWN_MOVER && remain_q == LEN_W'(1)) guard_q <= 2'd2;
            else if (guard_q != 2'd0)                           guard_q <= guard_q - 1'b1;
            spacing_err_o <= req_i[CL_MOVER] && (guard_q != 2'd0);
        end
    end

    // Host aging: count waiting cycles, allow one promotion per network grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_wait_q  <= '0;
            promo_used_q <= 1'b0;
        end else begin
            if (start && winner == OWN_HOST)
                host_wait_q <= '0;
            else if (req_i[CL_HOST] && owner_q != OWN_HOST && host_wait_q != '1)
                host_wait_q <= host_wait_q + 1'b1;
            if (start && winner == OWN_HOST && promote) promo_used_q <= 1'b1;
            else if (start && winner == OWN_NET)        promo_used_q <= 1'b0;
        end
    end

    // Grant decode from the current owner.
    always_comb begin
        gnt_o = '0;
        if (remain_q != '0) begin
            case (owner_q)
                OWN_RFSH:  gnt_o[GB_RFSH]  = 1'b1;
                OWN_MOVER: gnt_o[GB_MOVER] = 1'b1;
                OWN_NET:   gnt_o[GB_NET]   = 1'b1;
                OWN_HOST:  gnt_o[GB_HOST]  = 1'b1;
                default:   gnt_o = '0;
            endcase
        end
    end

    assign beat       = len_q - remain_q;
    assign cur_client = client_of(owner_q);
    assign cur_addr   = burst_q ? base_q + AW'(beat) : base_q;
    assign data_phase = (remain_q != '0) && (owner_q != OWN_RFSH) && (owner_q != OWN_NONE);

    // Memory array write port (no reset on storage).
    always_ff @(posedge clk) begin
        if (data_phase && wr_q) mem[cur_addr] <= wdata_a[cur_client];
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= data_phase && !wr_q;
            if (data_phase && !wr_q) rdata_o <= mem[cur_addr];
        end
    end

    // Network waiting counter used by the latency assertion.
    logic [NW_W-1:0] net_wait_q;
    always_ff @(posedge clk) begin
        if (!rst_n) net_wait_q <= '0;
        else if (req_i[CL_NET] && !gnt_o[GB_NET]) net_wait_q <= net_wait_q + 1'b1;
        else net_wait_q <= '0;
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (remain_q > LEN_W'(1)) |=> $stable(gnt_o));

    a_r6_refresh_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_pend && free) |=> gnt_o[GB_RFSH]);

    a_r8_mover_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnt_o[GB_MOVER]) |-> !gnt_o[GB_MOVER] ##1 !gnt_o[GB_MOVER]);

    a_r9_host_promoted: assert property (@(posedge clk) disable iff (!rst_n)
        (free && promote && elig[CL_HOST] && !rfsh_pend && !elig[CL_MOVER]) |=> gnt_o[GB_HOST]);

    a_r10_net_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_period_i > REF_W'(NET_BOUND)) |-> (net_wait_q <= NW_W'(NET_BOUND)));
endmodule

// File: tb/test_pkt_mem_arbiter.sv
`timescale 1ns/1ps
module test_pkt_mem_arbiter;
    localparam int AW = 6;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] period = 16'd60000;
    logic [7:0]  age = 8'd200;
    logic        req_b [3];
    logic        burst_b [3];
    logic        wr_b [3];
    logic [AW-1:0] addr_b [3];
    logic [DW-1:0] wdata_b [3];
    logic [2:0]    req_v, burst_v, wr_v;
    logic [3*AW-1:0] addr_v;
    logic [3*DW-1:0] wdata_v;
    logic [3:0]  gnt;
    logic [DW-1:0] rdata;
    logic        rvalid, serr;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 3; k++) begin
            req_v[k] = req_b[k];
            burst_v[k] = burst_b[k];
            wr_v[k] = wr_b[k];
            addr_v[k*AW +: AW] = addr_b[k];
            wdata_v[k*DW +: DW] = wdata_b[k];
        end
    end

    pkt_mem_arbiter i_pkt_mem_arbiter (
        .clk(clk), .rst_n(rst_n), .rfsh_period_i(period), .age_limit_i(age),
        .req_i(req_v), .burst_i(burst_v), .wr_i(wr_v), .addr_i(addr_v),
        .wdata_i(wdata_v), .gnt_o(gnt), .rdata_o(rdata), .rvalid_o(rvalid),
        .spacing_err_o(serr)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Grant run log and read log, written only by this monitor.
    int log_own [256];
    int log_start [256];
    int log_len [256];
    int n_log = 0;
    int open_idx [4];
    int run_len [4];
    logic [3:0] prev_g = '0;
    logic [DW-1:0] rd_log [256];
    int n_rd = 0;
    int onehot_bad = 0;

    always @(negedge clk) begin
        if (!rst_n) prev_g <= '0;
        else begin
            if ($countones(gnt) > 1) onehot_bad <= onehot_bad + 1;
            for (int g = 0; g < 4; g++) begin
                if (gnt[g] && !prev_g[g] && n_log < 256) begin
                    log_own[n_log] = g; log_start[n_log] = cyc; log_len[n_log] = 0;
                    open_idx[g] = n_log; run_len[g] = 1; n_log = n_log + 1;
                end else if (gnt[g]) run_len[g] = run_len[g] + 1;
                else if (prev_g[g]) log_len[open_idx[g]] = run_len[g];
            end
            if (rvalid && n_rd < 256) begin rd_log[n_rd] = rdata; n_rd = n_rd + 1; end
            prev_g <= gnt;
        end
    end

    function automatic logic [DW-1:0] pat(int k, int b);
        return {8'hA5, 8'(k), 8'h3C, 8'(b)};
    endfunction

    // Index of the nth grant run of an owner at or after log index from.
    function automatic int find_run(int own, int nth, int from);
        int seen = 0;
        for (int i = from; i < n_log; i++)
            if (log_own[i] == own) begin
                if (seen == nth) return i;
                seen++;
            end
        return -1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one access for client k; called right after a falling edge.
    task automatic drive(int k, bit bu, bit w, int a);
        int len;
        req_b[k] = 1'b1; burst_b[k] = bu; wr_b[k] = w; addr_b[k] = AW'(a);
        @(negedge clk);
        while (!gnt[k+1]) @(negedge clk);
        req_b[k] = 1'b0;
        len = (bu && k != 0) ? 8 : 1;
        for (int b = 0; b < len; b++) begin
            if (b > 0) @(negedge clk);
            wdata_b[k] = pat(k, b);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int b0, r0, c, i, s, t, g1;
        for (int k = 0; k < 3; k++) begin
            req_b[k] = 0; burst_b[k] = 0; wr_b[k] = 0; addr_b[k] = '0; wdata_b[k] = '0;
        end
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 gnt", int'(gnt), 0);
        chk("R1 rvalid", int'(rvalid), 0);
        chk("R1 spacing_err", int'(serr), 0);

        // R2/R11: host burst write to address 13 lands on words 8..15
        b0 = n_log;
        drive(2, 1, 1, 13);
        idle(3);
        i = find_run(3, 0, b0);
        chk("R2 host burst length", (i >= 0) ? log_len[i] : -1, 8);
        // R11: burst read of words 8..15 by the network stage
        b0 = n_log; r0 = n_rd;
        drive(1, 1, 0, 8);
        idle(3);
        i = find_run(2, 0, b0);
        chk("R2 net burst length", (i >= 0) ? log_len[i] : -1, 8);
        chk("R11 read beat count", n_rd - r0, 8);
        for (int b = 0; b < 8; b++)
            chk("R11 burst read data", int'(rd_log[r0 + b]), int'(pat(2, b)));
        // R11: a single-word read uses the exact address (word 11 = beat 3)
        b0 = n_log; r0 = n_rd;
        drive(1, 0, 0, 11);
        idle(3);
        i = find_run(2, 0, b0);
        chk("R2 single word length", (i >= 0) ? log_len[i] : -1, 1);
        chk("R11 single word data", int'(rd_log[r0]), int'(pat(2, 3)));

        // R3/R4/R10: simultaneous requests, host not aged enough
        b0 = n_log; c = cyc;
        fork
            drive(0, 0, 0, 0);
            drive(1, 0, 0, 1);
            drive(2, 0, 0, 2);
        join
        idle(3);
        chk("R3 first winner", log_own[b0], 1);
        chk("R3 second winner", log_own[b0+1], 2);
        chk("R3 third winner", log_own[b0+2], 3);
        chk("R3 idle grant latency", log_start[b0] - c, 1);
        chk("R4 no gap 1", log_start[b0+1] - log_start[b0], 1);
        chk("R4 no gap 2", log_start[b0+2] - log_start[b0+1], 1);
        chk("R10 network latency", log_start[b0+1] - c, 2);
        chk("R2 one-hot grants", onehot_bad, 0);

        // R9: with limit 0 the waiting host moves ahead of the network stage
        age = 8'd0;
        idle(2);
        b0 = n_log;
        fork
            drive(0, 0, 0, 0);
            drive(1, 0, 0, 1);
            drive(2, 0, 0, 2);
        join
        idle(3);
        chk("R9 mover still first", log_own[b0], 1);
        chk("R9 promoted host second", log_own[b0+1], 3);
        chk("R9 network third", log_own[b0+2], 2);
        age = 8'd200;

        // R7: mover burst flag ignored
        b0 = n_log;
        drive(0, 1, 0, 5);
        idle(3);
        i = find_run(1, 0, b0);
        chk("R7 mover length", (i >= 0) ? log_len[i] : -1, 1);

        // R8: mover requests again one cycle after its grant
        idle(3);
        b0 = n_log;
        req_b[0] = 1'b1; burst_b[0] = 1'b0; wr_b[0] = 1'b0;
        @(negedge clk);
        while (!gnt[1]) @(negedge clk);
        g1 = cyc;
        req_b[0] = 1'b0;
        @(negedge clk);
        req_b[0] = 1'b1;
        @(negedge clk);
        chk("R8 early request flagged", int'(serr), 1);
        while (!gnt[1]) @(negedge clk);
        req_b[0] = 1'b0;
        chk("R8 early request delayed", cyc - g1, 4);
        g1 = cyc;
        idle(3);
        req_b[0] = 1'b1;
        @(negedge clk);
        chk("R8 legal request not flagged", int'(serr), 0);
        chk("R8 legal request granted", int'(gnt[1]), 1);
        req_b[0] = 1'b0;
        chk("R8 legal request timing", cyc - g1, 4);

        // R5/R6: short refresh period
        period = 16'd40;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        b0 = n_log;
        t = 0;
        while (find_run(0, 1, b0) < 0 && t < 200) begin @(negedge clk); t++; end
        i = find_run(0, 0, b0);
        s = log_start[find_run(0, 1, b0)];
        chk("R5 refresh period", s - log_start[i], 40);
        chk("R2 refresh length", log_len[i], 2);
        while (cyc < s + 34) @(negedge clk);
        drive(2, 1, 1, 16);
        t = 0;
        while (find_run(0, 3, b0) < 0 && t < 200) begin @(negedge clk); t++; end
        i = find_run(3, 0, b0);
        chk("R6 host burst start", (i >= 0) ? log_start[i] - s : -1, 35);
        chk("R6 host burst unbroken", (i >= 0) ? log_len[i] : -1, 8);
        chk("R6 refresh after burst", log_start[find_run(0, 2, b0)] - s, 43);
        chk("R5 schedule kept", log_start[find_run(0, 3, b0)] - s, 80);

        done = 1;
        summary();
        $finish;
    end
endmodule